// File: doc/BRIEF.md
# Synchronous Burst Pseudo-Static RAM Read Engine

This block is the memory-side logic of a pseudo-static RAM. It answers two kinds of access on one set of pins. The first is a fixed-latency synchronous burst read. It starts when the address strobe is seen low on a clock edge, and it returns a short run of words on the data bus. The second is an address-latched write controlled by write enable. The chip opens it exactly like a read. It turns into a write when write enable falls before data is due. A small word array sits inside the block, so the engine can be exercised alone.

An open-drain style ready flag (`rdy_n`) tells the host when data is coming. It is low while the host must wait, high one clock before the first word and through the last one, and released to high impedance while the chip is deselected. All pins are sampled on the rising edge of `clk`. Latency, burst length, array size and the open-burst time limit are parameters.

Top module: `psram_burst_engine`

## Requirements
- R1: Out of reset, with `sel_n` high, `rdy_n` and `dq` are high impedance and `burst_err` is 0. With `sel_n` low and no burst open, `rdy_n` is driven 0.
- R2: A burst starts on an edge where `sel_n` is low, `stb_n` is low after being high at the previous edge, the engine is idle, and `wr_n` is high at that edge and the previous one. If `stb_n` is held low after that edge, no further burst starts, even after the current one has ended.
- R3: Count the start edge as edge 0. `rdy_n` is driven 1 from edge LAT-1 until edge LAT+BL. At all other times while `sel_n` is low it is driven 0. Whenever `sel_n` is high it is high impedance.
- R4: Beat i (0 to BL-1) appears on `dq` from edge LAT+i. It reads the word at `(A & ~(BL-1)) | ((A+i) & (BL-1))`, where A is the address at the start edge. The read wraps inside an aligned group of BL words.
- R5: `dq` is driven only when `sel_n` and `oe_n` are both low during a data beat. Otherwise it is high impedance.
- R6: A new falling `stb_n` while a burst is open is ignored. The beat sequence continues unchanged.
- R7: If `wr_n` is sampled low at an edge before edge LAT-1, the burst becomes a write to address A. `dq` is captured at each edge where `wr_n` is low. At the edge where `wr_n` is first seen high again, the word is written. `lb_n` low enables bits 7:0 and `ub_n` low enables bits 15:8.
- R8: No burst can start on the edge that sees `wr_n` return high. A burst can start one edge later.
- R9: An edge with `sel_n` high closes any burst or pending write. `rdy_n` then stays driven 0 while `sel_n` is low again without a new start.
- R10: `burst_err` rises after edge TMO of a burst whose `sel_n` has stayed low. It holds through deselection and clears at the next burst start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock, all pins sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Chip select, active low |
| stb_n | input | 1 | Address-valid strobe, active low |
| wr_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Lower byte lane enable for writes, active low |
| ub_n | input | 1 | Upper byte lane enable for writes, active low |
| addr | input | AW | Word address |
| dq | inout | 16 | Bidirectional data bus |
| rdy_n | output | 1 | Ready flag: 0 wait, 1 data due, high impedance when deselected |
| burst_err | output | 1 | Burst held open past the time limit |

## Verification
The bench builds the engine with a 32-word array (AW=5), the default latency of 5 and burst length of 4, and a time limit of 24 clocks. The small array allows every start address to be swept, so every wrap offset inside every aligned group is checked against words written beforehand. The short limit brings the open-burst error flag within a few dozen cycles. Both high-impedance pins are pulled up in the bench, so a released pin reads as all ones, a value no written pattern uses.

// File: rtl/psram_pkg.sv
package psram_pkg;

  localparam int DW    = 16;
  localparam int LANES = DW / 8;

  typedef struct packed {
    logic stb_fall;
    logic wr_rise;
    logic wr_quiet;
  } pin_evt_t;

endpackage

// File: rtl/psram_pin_sampler.sv
module psram_pin_sampler
  import psram_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     stb_n,
  input  logic     wr_n,
  output pin_evt_t evt
);

  logic stb_q, stb_d;
  logic wr_q, wr_d;

  always_comb begin
    stb_d = stb_n;
    wr_d  = wr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b1;
      wr_q  <= 1'b1;
    end else begin
      stb_q <= stb_d;
      wr_q  <= wr_d;
    end
  end

  always_comb begin
    evt.stb_fall = !stb_n && stb_q;
    evt.wr_rise  = wr_n && !wr_q;
    evt.wr_quiet = wr_n && wr_q;
  end

endmodule

// File: rtl/psram_burst_seq.sv
module psram_burst_seq
  import psram_pkg::*;
#(
  parameter int AW  = 6,
  parameter int LAT = 5,
  parameter int BL  = 4,
  parameter int TMO = 125,
  localparam int CW = $clog2(LAT + BL + 1),
  localparam int BW = $clog2(BL),
  localparam int TW = $clog2(TMO + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             wr_n,
  input  logic [LANES-1:0] lane_n,
  input  pin_evt_t         evt,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    dq_in,
  output logic [CW-1:0]    rd_cnt,
  output logic             start,
  output logic             wait_hi,
  output logic             beat_vld,
  output logic [AW-1:0]    beat_addr,
  output logic             wr_en,
  output logic [LANES-1:0] wr_be,
  output logic [AW-1:0]    wr_addr,
  output logic [DW-1:0]    wr_data,
  output logic             err
);

  localparam logic [CW-1:0] CNT_LAST  = CW'(LAT + BL);
  localparam logic [CW-1:0] CNT_RDY   = CW'(LAT);
  localparam logic [CW-1:0] CNT_BEAT0 = CW'(LAT + 1);
  localparam logic [TW-1:0] TMO_LAST  = TW'(TMO - 1);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic             wmode_q, wmode_d;
  logic [AW-1:0]    base_q, base_d;
  logic             open_q, open_d;
  logic [TW-1:0]    tmo_q, tmo_d;
  logic             err_q, err_d;
  logic [DW-1:0]    wdat_q, wdat_d;
  logic [LANES-1:0] wbe_q, wbe_d;

  logic idle, convert, capture, commit;
  logic [BW-1:0] beat_off;

  always_comb begin
    idle    = (cnt_q == '0) && !wmode_q;
    start   = idle && !sel_n && evt.stb_fall && evt.wr_quiet;
    convert = (cnt_q != '0) && (cnt_q < CNT_RDY - CW'(1)) && !sel_n && !wr_n;
    capture = (wmode_q || convert) && !sel_n && !wr_n;
    commit  = wmode_q && !sel_n && evt.wr_rise;
  end

  always_comb begin
    cnt_d   = cnt_q;
    wmode_d = wmode_q;
    base_d  = base_q;
    open_d  = open_q;
    tmo_d   = tmo_q;
    err_d   = err_q;
    wdat_d  = wdat_q;
    wbe_d   = wbe_q;

    if (sel_n) begin
      cnt_d   = '0;
      wmode_d = 1'b0;
      open_d  = 1'b0;
    end else if (start) begin
      cnt_d  = CW'(1);
      base_d = addr;
      open_d = 1'b1;
      tmo_d  = '0;
      err_d  = 1'b0;
    end else if (convert) begin
      cnt_d   = '0;
      wmode_d = 1'b1;
      open_d  = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_d = (cnt_q == CNT_LAST) ? '0 : cnt_q + CW'(1);
    end

    if (capture) begin
      wdat_d = dq_in;
      wbe_d  = ~lane_n;
    end
    if (commit) begin
      wmode_d = 1'b0;
    end

    if (open_q && !sel_n && !start && !convert && !err_q) begin
      if (tmo_q == TMO_LAST) begin
        err_d = 1'b1;
      end else begin
        tmo_d = tmo_q + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      wmode_q <= 1'b0;
      base_q  <= '0;
      open_q  <= 1'b0;
      tmo_q   <= '0;
      err_q   <= 1'b0;
      wdat_q  <= '0;
      wbe_q   <= '0;
    end else begin
      cnt_q   <= cnt_d;
      wmode_q <= wmode_d;
      base_q  <= base_d;
      open_q  <= open_d;
      tmo_q   <= tmo_d;
      err_q   <= err_d;
      wdat_q  <= wdat_d;
      wbe_q   <= wbe_d;
    end
  end

  always_comb begin
    beat_off  = BW'(cnt_q - CNT_BEAT0);
    rd_cnt    = cnt_q;
    wait_hi   = cnt_q >= CNT_RDY;
    beat_vld  = cnt_q >= CNT_BEAT0;
    beat_addr = {base_q[AW-1:BW], base_q[BW-1:0] + beat_off};
    wr_en     = commit;
    wr_be     = wbe_q;
    wr_addr   = base_q;
    wr_data   = wdat_q;
    err       = err_q;
  end

endmodule

// File: rtl/psram_word_array.sv
module psram_word_array
  import psram_pkg::*;
#(
  parameter int AW = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             we,
  input  logic [LANES-1:0] be,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && be[l]) begin
        mem[waddr] <= wdata[l*8 +: 8];
      end
    end

    assign rdata[l*8 +: 8] = mem[raddr];
  end

endmodule

// File: rtl/psram_burst_engine.sv
module psram_burst_engine
  import psram_pkg::*;
#(
  parameter int AW  = 6,
  parameter int LAT = 5,
  parameter int BL  = 4,
  parameter int TMO = 125,
  localparam int CW = $clog2(LAT + BL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          stb_n,
  input  logic          wr_n,
  input  logic          oe_n,
  input  logic          lb_n,
  input  logic          ub_n,
  input  logic [AW-1:0] addr,
  inout  wire  [15:0]   dq,
  output wire           rdy_n,
  output logic          burst_err
);

  pin_evt_t         evt;
  logic [CW-1:0]    rd_cnt_w;
  logic             start_w;
  logic             wait_hi_w;
  logic             beat_vld_w;
  logic [AW-1:0]    beat_addr_w;
  logic             wr_en_w;
  logic [LANES-1:0] wr_be_w;
  logic [AW-1:0]    wr_addr_w;
  logic [DW-1:0]    wr_data_w;
  logic [DW-1:0]    rdata_w;
  logic             dq_drive_w;

  psram_pin_sampler u_smp (
    .clk   (clk),
    .rst_n (rst_n),
    .stb_n (stb_n),
    .wr_n  (wr_n),
    .evt   (evt)
  );

  psram_burst_seq #(
    .AW  (AW),
    .LAT (LAT),
    .BL  (BL),
    .TMO (TMO)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n     (sel_n),
    .wr_n      (wr_n),
    .lane_n    ({ub_n, lb_n}),
    .evt       (evt),
    .addr      (addr),
    .dq_in     (dq),
    .rd_cnt    (rd_cnt_w),
    .start     (start_w),
    .wait_hi   (wait_hi_w),
    .beat_vld  (beat_vld_w),
    .beat_addr (beat_addr_w),
    .wr_en     (wr_en_w),
    .wr_be     (wr_be_w),
    .wr_addr   (wr_addr_w),
    .wr_data   (wr_data_w),
    .err       (burst_err)
  );

  psram_word_array #(
    .AW (AW)
  ) u_arr (
    .clk   (clk),
    .we    (wr_en_w),
    .be    (wr_be_w),
    .waddr (wr_addr_w),
    .wdata (wr_data_w),
    .raddr (beat_addr_w),
    .rdata (rdata_w)
  );

  assign dq_drive_w = !sel_n && !oe_n && beat_vld_w;
  assign dq         = dq_drive_w ? rdata_w : 16'hzzzz;
  assign rdy_n      = sel_n ? 1'bz : wait_hi_w;

endmodule

// File: rtl/psram_burst_chk.sv
module psram_burst_chk #(
  parameter int LAT = 5,
  parameter int BL  = 4
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            sel_n,
  input logic                            wr_n,
  input logic                            burst_err,
  input logic [$clog2(LAT+BL+1)-1:0]     rd_cnt,
  input logic                            start,
  input logic                            wait_hi,
  input logic                            dq_drive,
  input logic                            wr_en
);

  // R4
  beat_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_drive |-> wait_hi);

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> rd_cnt == 1);

  // R6
  busy_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cnt != 0) && (rd_cnt != LAT + BL) && !sel_n && wr_n
      |=> rd_cnt == $past(rd_cnt) + 1'b1);

  // R9
  desel_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> rd_cnt == 0);

  // R10
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_err) |-> $past(!sel_n));

  // R7
  write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (rd_cnt == 0) && !start);

endmodule

bind psram_burst_engine psram_burst_chk #(
  .LAT (LAT),
  .BL  (BL)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_n     (sel_n),
  .wr_n      (wr_n),
  .burst_err (burst_err),
  .rd_cnt    (rd_cnt_w),
  .start     (start_w),
  .wait_hi   (wait_hi_w),
  .dq_drive  (dq_drive_w),
  .wr_en     (wr_en_w)
);

// File: tb/tb_psram_burst_engine.sv
`timescale 1ns/1ps
module tb_psram_burst_engine;

  localparam int AW  = 5;
  localparam int LAT = 5;
  localparam int BL  = 4;
  localparam int TMO = 24;
  localparam int NW  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel_n, stb_n, wr_n, oe_n, lb_n, ub_n;
  logic [AW-1:0] addr;
  logic          drv_en;
  logic [15:0]   drv_val;
  wire  [15:0]   dq;
  wire           rdy_n;
  logic          burst_err;

  logic [15:0] exp_mem [NW];
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  assign dq = drv_en ? drv_val : 16'hzzzz;
  for (genvar b = 0; b < 16; b++) begin : g_pu
    pullup (dq[b]);
  end
  pullup (rdy_n);

  psram_burst_engine #(.AW(AW), .LAT(LAT), .BL(BL), .TMO(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .stb_n(stb_n), .wr_n(wr_n),
    .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .dq(dq),
    .rdy_n(rdy_n), .burst_err(burst_err)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int wrap_addr(input int a, input int i);
    return (a & ~(BL - 1)) | ((a + i) & (BL - 1));
  endfunction

  // mode 0: plain, 1: oe_n high, 2: strobe held low and re-dropped mid burst
  task automatic burst_read(input int a, input int mode);
    @(negedge clk);
    sel_n = 1'b0; stb_n = 1'b0; addr = AW'(a); wr_n = 1'b1; oe_n = (mode == 1);
    for (int j = 0; j <= LAT + BL; j++) begin
      @(negedge clk);
      if (mode != 2 && j == 0) stb_n = 1'b1;
      if (mode == 2 && j == 2) stb_n = 1'b1;
      if (mode == 2 && j == 3) stb_n = 1'b0;
      #4;
      chk((mode == 2) ? "R6 ready" : "R3 ready", {15'd0, rdy_n},
          {15'd0, (j >= LAT - 1 && j <= LAT + BL - 1)});
      if (j >= LAT && j <= LAT + BL - 1 && mode != 1)
        chk("R4 beat", dq, exp_mem[wrap_addr(a, j - LAT)]);
      else
        chk("R5 bus released", dq, 16'hffff);
    end
    if (mode == 2) begin
      for (int k = 0; k < 2; k++) begin
        @(negedge clk); #4;
        chk("R2 no restart", {15'd0, rdy_n}, 16'd0);
      end
    end
    @(negedge clk);
    sel_n = 1'b1; stb_n = 1'b1; oe_n = 1'b1;
  endtask

  // follow 0: none, 1: strobe at the write-end edge, 2: strobe one edge later
  task automatic write_word(input int a, input logic [15:0] d, input bit lo, input bit hi,
                            input int follow);
    @(negedge clk);
    sel_n = 1'b0; stb_n = 1'b0; addr = AW'(a); wr_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    stb_n = 1'b1;
    @(negedge clk);
    wr_n = 1'b0; drv_en = 1'b1; drv_val = d; lb_n = !lo; ub_n = !hi;
    @(negedge clk);
    wr_n = 1'b1; drv_en = 1'b0; stb_n = (follow == 1) ? 1'b0 : 1'b1;
    if (follow == 1) begin
      oe_n = 1'b0;
      for (int j = 0; j <= LAT + 1; j++) begin
        @(negedge clk); #4;
        chk("R8 start blocked", {15'd0, rdy_n}, 16'd0);
        chk("R8 bus idle", dq, 16'hffff);
      end
    end
    if (follow == 2) begin
      @(negedge clk);
      stb_n = 1'b0;
      for (int j = 0; j < LAT; j++) begin
        @(negedge clk);
        stb_n = 1'b1; #4;
        chk("R8 start after gap", {15'd0, rdy_n}, {15'd0, (j == LAT - 1)});
      end
    end
    @(negedge clk);
    sel_n = 1'b1; stb_n = 1'b1; lb_n = 1'b1; ub_n = 1'b1; oe_n = 1'b1;
    if (lo) exp_mem[a][7:0]  = d[7:0];
    if (hi) exp_mem[a][15:8] = d[15:8];
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sel_n = 1'b1; stb_n = 1'b1; wr_n = 1'b1; oe_n = 1'b1;
    lb_n = 1'b1; ub_n = 1'b1; addr = '0; drv_en = 1'b0; drv_val = '0;
    repeat (3) @(negedge clk);
    #4;
    // R1 reset state
    chk("R1 ready released", {15'd0, rdy_n}, 16'd1);
    chk("R1 bus released", dq, 16'hffff);
    chk("R1 error clear", {15'd0, burst_err}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    sel_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); #4;
    chk("R1 ready low when selected", {15'd0, rdy_n}, 16'd0);
    chk("R1 bus idle", dq, 16'hffff);
    sel_n = 1'b1; oe_n = 1'b1;

    for (int a = 0; a < NW; a++) begin
      exp_mem[a] = 16'hxxxx;
      write_word(a, 16'(a * 16'h0137 + 16'h1000), 1'b1, 1'b1, 0);
    end
    // R7 byte lanes
    write_word(3,  16'h5ac3, 1'b1, 1'b0, 0);
    write_word(9,  16'h7e11, 1'b0, 1'b1, 0);
    write_word(12, 16'h0f0f, 1'b0, 1'b0, 0);
    write_word(20, 16'h6d2b, 1'b1, 1'b1, 1);
    write_word(21, 16'h4c84, 1'b1, 1'b1, 2);

    // R4 every start address, all wrap offsets
    for (int a = 0; a < NW; a++) burst_read(a, 0);
    burst_read(6, 1);
    burst_read(5, 2);

    // R9 deselect mid burst
    @(negedge clk);
    sel_n = 1'b0; stb_n = 1'b0; addr = AW'(8); oe_n = 1'b0;
    @(negedge clk);
    stb_n = 1'b1;
    @(negedge clk);
    sel_n = 1'b1;
    @(negedge clk);
    sel_n = 1'b0;
    for (int j = 0; j <= LAT + 2; j++) begin
      @(negedge clk); #4;
      chk("R9 ready stays low", {15'd0, rdy_n}, 16'd0);
      chk("R9 bus idle", dq, 16'hffff);
    end
    @(negedge clk);
    sel_n = 1'b1; oe_n = 1'b1;

    // R10 open-burst limit
    @(negedge clk);
    sel_n = 1'b0; stb_n = 1'b0; addr = '0;
    for (int j = 0; j <= TMO; j++) begin
      @(negedge clk);
      if (j == 0) stb_n = 1'b1;
      #4;
      if (j == 0 || j == TMO - 1 || j == TMO)
        chk("R10 limit", {15'd0, burst_err}, {15'd0, (j >= TMO)});
    end
    @(negedge clk);
    sel_n = 1'b1;
    @(negedge clk); #4;
    chk("R10 sticky", {15'd0, burst_err}, 16'd1);
    @(negedge clk);
    sel_n = 1'b0; stb_n = 1'b0;
    @(negedge clk);
    stb_n = 1'b1; #4;
    chk("R10 cleared by start", {15'd0, burst_err}, 16'd0);
    @(negedge clk);
    sel_n = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule